// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps the status half of a serial port's modem interface. It watches four incoming handshake lines (clear-to-send, data-set-ready, carrier detect and ring indicator) through a two-stage synchronizer. It presents their current levels together with four sticky change flags as one 8-bit status byte. It raises a single change indication that an interrupt unit can mask and prioritise.

The block also holds the 5-bit modem control value. That value drives the outgoing request-to-send and data-terminal-ready lines, and it carries a loopback switch. When loopback is on, the status levels are taken crosswise from the control bits instead of the pins, and the outgoing lines are held inactive. A host read strobe returns the status byte and clears the change flags. A change that lands in the same cycle as the read is kept.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, stat_q reads 0xB0 and ctl_q reads 0x08; rts_out, dtr_out and chg_irq are low. Status byte layout from bit 7 down: carrier, ring, data-set-ready, clear-to-send, carrier-changed, ring-ended, data-set-ready-changed, clear-to-send-changed.
- R2: A level change on a modem input pin appears in the upper nibble of stat_q after the third rising clock edge that follows it. Two synchronizer stages and the status register lie on that path.
- R3: Bits 3, 1 and 0 of stat_q are set when the carrier, data-set-ready or clear-to-send level changes in either direction. Once set, they stay set until a read clears them.
- R4: Bit 2 of stat_q is set only when the ring level goes from 1 to 0. A 0-to-1 change of the ring level leaves bit 2 unchanged.
- R5: While stat_rd is high, stat_q shows the current status byte. At the following edge, all four change flags are cleared.
- R6: A status change that is registered at the same edge as a read sets its flag, and that flag survives the clear.
- R7: chg_irq is high exactly when any of stat_q bits 3..0 is set.
- R8: When ctl_we is high, ctl_wdata is stored and shows on ctl_q from the next cycle. With ctl_q bit 4 clear, rts_out follows ctl_q bit 1 and dtr_out follows ctl_q bit 0.
- R9: With ctl_q bit 4 set (loopback), the status levels follow the control bits one edge later: bit 3 to carrier, bit 2 to ring, bit 1 to clear-to-send, bit 0 to data-set-ready. The pins have no effect in this mode, and rts_out and dtr_out are low.
- R10: Entering or leaving loopback compares the new source against the held levels, so any difference sets change flags under the rules of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| dsr_in | input | 1 | Data-set-ready pin, asynchronous |
| dcd_in | input | 1 | Carrier-detect pin, asynchronous |
| ri_in | input | 1 | Ring-indicator pin, asynchronous |
| ctl_we | input | 1 | Write strobe for the control value |
| ctl_wdata | input | 5 | Control value to write |
| ctl_q | output | 5 | Current control value |
| stat_rd | input | 1 | Host read strobe for the status byte |
| stat_q | output | 8 | Status byte: levels and change flags |
| chg_irq | output | 1 | Any change flag set |
| rts_out | output | 1 | Request-to-send pin drive |
| dtr_out | output | 1 | Data-terminal-ready pin drive |

## Verification
Two functions can act in the same cycle: the read-clear of the change flags and the setting of a flag by a newly registered level change. To provoke this, the bench lowers data-set-ready while the carrier flag is already set. It then raises stat_rd in exactly the cycle whose closing edge registers the new level. The check requires that the read cycle shows the old byte, and that afterwards the carrier flag is gone while the data-set-ready flag remains. A randomised phase with reads, control writes and pin toggling keeps hitting this overlap. Every cycle there is compared with a behavioural queue-based model.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  // status nibble order (also the change-flag order)
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;
  localparam int unsigned NLINES = 4;

  // control value bit positions
  localparam int unsigned CB_DTR  = 0;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_OUT1 = 2;
  localparam int unsigned CB_OUT2 = 3;
  localparam int unsigned CB_LOOP = 4;
  localparam int unsigned CTL_W   = 5;

  typedef logic [NLINES-1:0] line_vec_t;
  typedef logic [CTL_W-1:0]  ctl_vec_t;

  localparam line_vec_t LINE_RST = 4'b1011; // carrier, dsr, cts high
  localparam ctl_vec_t  CTL_RST  = 5'b01000; // only OUT2 high
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mstat_ctl.sv
module mstat_ctl
  import mstat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  ctl_vec_t wdata,
  output ctl_vec_t ctl,
  output logic     rts_out,
  output logic     dtr_out
);
  ctl_vec_t ctl_d;
  logic     ctl_en;

  always_comb begin
    ctl_en = we;
    ctl_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= CTL_RST;
    else if (ctl_en) ctl <= ctl_d;
  end

  // outgoing handshake lines are parked inactive during loopback
  always_comb begin
    rts_out = ctl[CB_RTS] & ~ctl[CB_LOOP];
    dtr_out = ctl[CB_DTR] & ~ctl[CB_LOOP];
  end
endmodule

// File: rtl/mstat_track.sv
module mstat_track
  import mstat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t pins_sync,
  input  ctl_vec_t  ctl,
  input  logic      rd,
  output line_vec_t level,
  output line_vec_t flags
);
  line_vec_t src, diff, hit, level_d, flags_d;
  logic      level_en, flags_en;

  always_comb begin
    if (ctl[CB_LOOP]) begin
      src[LN_DCD] = ctl[CB_OUT2];
      src[LN_RI]  = ctl[CB_OUT1];
      src[LN_DSR] = ctl[CB_DTR];
      src[LN_CTS] = ctl[CB_RTS];
    end else begin
      src = pins_sync;
    end
    diff = src ^ level;
    hit  = diff;
    // ring flag marks only the trailing (1 -> 0) edge
    hit[LN_RI] = level[LN_RI] & ~src[LN_RI];
    level_d  = src;
    level_en = |diff;
    // a fresh hit wins over the read clear in the same cycle
    flags_d  = (rd ? '0 : flags) | hit;
    flags_en = rd | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level <= LINE_RST;
    else if (level_en) level <= level_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_d;
  end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import mstat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       dcd_in,
  input  logic       ri_in,
  input  logic       ctl_we,
  input  logic [4:0] ctl_wdata,
  output logic [4:0] ctl_q,
  input  logic       stat_rd,
  output logic [7:0] stat_q,
  output logic       chg_irq,
  output logic       rts_out,
  output logic       dtr_out
);
  line_vec_t pins_raw, pins_sync, level, flags;
  ctl_vec_t  ctl;

  always_comb begin
    pins_raw[LN_CTS] = cts_in;
    pins_raw[LN_DSR] = dsr_in;
    pins_raw[LN_RI]  = ri_in;
    pins_raw[LN_DCD] = dcd_in;
  end

  mstat_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync)
  );

  mstat_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl(ctl), .rts_out(rts_out), .dtr_out(dtr_out)
  );

  mstat_track u_track (
    .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .ctl(ctl),
    .rd(stat_rd), .level(level), .flags(flags)
  );

  always_comb begin
    ctl_q   = ctl;
    stat_q  = {level, flags};
    chg_irq = |flags;
  end
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic [7:0] stat_q,
  input logic [4:0] ctl_q,
  input logic       chg_irq,
  input logic       rts_out,
  input logic       dtr_out
);
  // R3: flags never drop without a read
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

  // R3: a changed level has its flag set
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q[7] != $past(stat_q[7])) |-> stat_q[3]) and
    ((stat_q[5] != $past(stat_q[5])) |-> stat_q[1]) and
    ((stat_q[4] != $past(stat_q[4])) |-> stat_q[0]));

  // R4: ring flag can only appear together with a falling ring level
  assert_ring_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[2]) |-> $fell(stat_q[6]));

  // R5: after a read, flags remain only if a level moved at that edge
  assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((stat_q[3:0] == 4'd0) || (stat_q[7:4] != $past(stat_q[7:4]))));

  // R7: change indication tracks the flags
  assert_chg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_irq == (stat_q[3:0] != 4'd0));

  // R9: outgoing lines parked in loopback
  assert_loop_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> (!rts_out && !dtr_out));

  // R9: loopback levels follow the control bits one edge later
  assert_loop_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_q[4]) && ctl_q[4]) |->
      (stat_q[7:4] == {$past(ctl_q[3]), $past(ctl_q[2]), $past(ctl_q[0]), $past(ctl_q[1])}));
endmodule

bind modem_status_unit mstat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_q(stat_q),
  .ctl_q(ctl_q), .chg_irq(chg_irq), .rts_out(rts_out), .dtr_out(dtr_out)
);

// File: tb/modem_status_unit_tb.sv
module modem_status_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_in = 1'b1, dsr_in = 1'b1, dcd_in = 1'b1, ri_in = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_q;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_q;
  logic       chg_irq, rts_out, dtr_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  modem_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .dsr_in(dsr_in),
    .dcd_in(dcd_in), .ri_in(ri_in), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .stat_rd(stat_rd), .stat_q(stat_q), .chg_irq(chg_irq),
    .rts_out(rts_out), .dtr_out(dtr_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural reference model ----
  logic [3:0] m_pipe[$];   // pin history, oldest first
  logic [3:0] m_lvl, m_flg;   // {dcd,ri,dsr,cts}
  logic [4:0] m_ctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = {4'b1011, 4'b1011};
      m_lvl  = 4'b1011;
      m_flg  = 4'b0000;
      m_ctl  = 5'b01000;
    end else begin
      logic [3:0] src;
      logic [3:0] nf;
      if (m_ctl[4]) src = {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
      else          src = m_pipe[0];
      nf = stat_rd ? 4'b0000 : m_flg;
      for (int i = 0; i < 4; i++) begin
        if (i == 2) begin
          if (m_lvl[2] == 1'b1 && src[2] == 1'b0) nf[2] = 1'b1;
        end else if (m_lvl[i] != src[i]) nf[i] = 1'b1;
      end
      m_flg = nf;
      m_lvl = src;
      void'(m_pipe.pop_front());
      m_pipe.push_back({dcd_in, ri_in, dsr_in, cts_in});
      if (ctl_we) m_ctl = ctl_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4/R6 status byte vs model", stat_q, {m_lvl, m_flg});
      chk("R7 change indication vs model", {7'd0, chg_irq}, {7'd0, (m_flg != 0)});
      chk("R8 control value vs model", {3'd0, ctl_q}, {3'd0, m_ctl});
      chk("R8/R9 rts/dtr vs model", {6'd0, rts_out, dtr_out},
          {6'd0, m_ctl[1] & ~m_ctl[4], m_ctl[0] & ~m_ctl[4]});
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_we = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string tag);
    stat_rd = 1'b1;
    chk(tag, stat_q, exp);
    tick(1);
    stat_rd = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status after reset", stat_q, 8'hB0);
    chk("R1 control after reset", {3'd0, ctl_q}, 8'h08);
    chk("R1 rts/dtr/chg after reset", {5'd0, rts_out, dtr_out, chg_irq}, 8'h00);

    // R2 latency and R3 set on clear-to-send drop
    cts_in = 1'b0;
    tick(2);
    chk("R2 not yet visible after two edges", stat_q, 8'hB0);
    tick(1);
    chk("R2/R3 cts drop seen on third edge", stat_q, 8'hA1);
    chk("R7 chg on flag", {7'd0, chg_irq}, 8'h01);
    cts_in = 1'b1;
    tick(3);
    chk("R3 flag sticky after restore", stat_q, 8'hB1);

    // R5 read clear
    do_read(8'hB1, "R5 read shows current byte");
    chk("R5 flags cleared after read", stat_q, 8'hB0);
    chk("R7 chg low after clear", {7'd0, chg_irq}, 8'h00);

    // R4 ring edges
    ri_in = 1'b1;
    tick(3);
    chk("R4 ring rise sets no flag", stat_q, 8'hF0);
    ri_in = 1'b0;
    tick(3);
    chk("R4 ring fall sets bit 2", stat_q, 8'hB4);
    do_read(8'hB4, "R5 read before ring clear");

    // R6 read and new change at the same edge
    dcd_in = 1'b0;
    tick(3);
    chk("R3 carrier drop", stat_q, 8'h38);
    dsr_in = 1'b0;
    tick(2);
    do_read(8'h38, "R5 read in overlap cycle");
    chk("R6 new flag survives same-edge read", stat_q, 8'h12);
    dcd_in = 1'b1; dsr_in = 1'b1;
    tick(3);
    do_read(8'hBA, "R5 read after restore");
    chk("R5 clean after restore", stat_q, 8'hB0);

    // R8 control write, normal mode
    wr_ctl(5'h03);
    chk("R8 control stored", {3'd0, ctl_q}, 8'h03);
    chk("R8 rts/dtr follow control", {6'd0, rts_out, dtr_out}, 8'h03);

    // R9/R10 loopback
    wr_ctl(5'h1D);
    chk("R9 rts/dtr parked in loopback", {6'd0, rts_out, dtr_out}, 8'h00);
    tick(1);
    chk("R9/R10 loopback mapping and entry flags", stat_q, 8'hE1);
    cts_in = 1'b0; dcd_in = 1'b0;
    tick(4);
    chk("R9 pins ignored in loopback", stat_q, 8'hE1);
    wr_ctl(5'h19);
    tick(1);
    chk("R9/R4 OUT1 drop gives ring flag", stat_q, 8'hA5);
    dcd_in = 1'b1;
    tick(3);
    wr_ctl(5'h08);
    tick(1);
    chk("R10 leaving loopback, pins match", stat_q, 8'hA5);

    // randomised phase, judged by the model each cycle
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cts_in = r[0]; dsr_in = r[1]; dcd_in = r[2]; ri_in = r[3];
      stat_rd = (r[5:4] == 2'b00);
      ctl_we  = (r[9:6] == 4'b0000);
      ctl_wdata = r[14:10];
      tick(1);
    end
    stat_rd = 1'b0; ctl_we = 1'b0;
    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule